// File: doc/BRIEF.md
# Two-Hit Pixel Time-Stamp Cell

This block is the digital part of one pixel in a sparsified pixel matrix. The work is split into two phases chosen by a phase select input. In the detection phase a shared time-stamp counter drives a 5-bit bus to every pixel. Each pixel keeps two stamp registers that follow that bus. On the first discriminator hit the first register stops and keeps the stamp. On the second hit the second register does the same. Any further hit in that window is dropped. A one-bit kill mask is loaded through a serial chain that runs from pixel to pixel. A masked pixel records nothing.

In the readout phase the pixels form a token chain. A pixel with nothing stored, or a masked pixel, passes the incoming token straight through in the same cycle. A pixel with stored hits keeps the token. On the next clock edge it raises its column-select and row-select lines and presents its oldest stamp on the shared stamp bus. This output is a valid/ready stream: the select lines act as valid, and the downstream serializer answers with a ready input. A word stays on the bus, unchanged, until a cycle in which ready is high. With ready held high, the pixel delivers one word per clock. When the last stored hit is accepted, the pixel's flags are clear and the token moves on. An active-low master reset clears the stored hits and any pending output. It leaves the kill mask as it was.

Top module: `pxl_twohit_cell`

## Requirements
- R1: In the detection phase (`ro_en`=0), each clock cycle in which `hit_i` is high and the pixel is unmasked counts as one hit. The first hit stores the value that `ts_bus` has at that clock edge. That stamp is held until it is read out.
- R2: A second hit in the same window stores the `ts_bus` value at its own edge in a separate register. The first stamp is not changed.
- R3: A third or later hit, while two hits are stored, changes neither stored stamp and produces no extra output word.
- R4: On each clock edge with `mask_shift`=1, the kill-mask bit takes the value of `mask_si`. `mask_so` always shows the stored bit, which is the serial output of the chain. Master reset does not change this bit (1 = masked).
- R5: While the mask bit is 1, hits are not recorded. During readout such a pixel passes `tok_in` to `tok_out` combinationally.
- R6: Hits that arrive while `ro_en`=1 are ignored.
- R7: A pixel with no stored hits drives `tok_out` equal to `tok_in` in the same cycle.
- R8: In readout, if the pixel holds data and `tok_in` is 1, then on the next clock edge `get_x` and `get_y` both go to 1 and `ts_out` shows the first-hit stamp. `tok_out` stays 0 for as long as the pixel holds data.
- R9: While `get_x` is 1 and `out_ready` is 0, `get_x`, `get_y` and `ts_out` stay unchanged. An accepted first word that has a second hit behind it is followed, on the very next edge, by the second stamp: one clock per hit.
- R10: After the last stored word is accepted, the select lines drop and `ts_out` reads 0. From then on `tok_out` follows `tok_in`.
- R11: When `rst_n` is 0, the stored hits and the output valid are cleared at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| ts_bus | input | 5 | Time-stamp value broadcast to all pixels |
| hit_i | input | 1 | Discriminator hit, one hit per high cycle |
| ro_en | input | 1 | Phase select: 0 detection, 1 readout |
| mask_shift | input | 1 | Mask chain shift strobe |
| mask_si | input | 1 | Mask chain serial input |
| mask_so | output | 1 | Mask chain serial output (stored mask bit) |
| tok_in | input | 1 | Readout token from the previous pixel |
| tok_out | output | 1 | Readout token to the next pixel |
| get_x | output | 1 | Column select, valid of the output stream |
| get_y | output | 1 | Row select, asserted together with get_x |
| ts_out | output | 5 | Stamp of the word being read out, 0 when idle |
| out_ready | input | 1 | Downstream ready for the output stream |

## Verification
The bench aims at the cases where the order of events matters. These are a third hit after two stored ones, hits that arrive during readout or while masked, a stall in the middle of a two-word readout, and a reset while a word is waiting. Each one exposes a typical fault. A design that let the first stamp keep following the bus would read out a recent count instead of the hit time. One that overwrote on a third hit would report wrong stamps. One that released the token early would let the next pixel drive the shared bus at the same time. One that dropped or advanced a word during a stall would lose or duplicate a hit. The reference model also checks that the kill mask survives a master reset, and that an empty or masked pixel passes the token within the same cycle.

// File: rtl/pxl_ts_pkg.sv
package pxl_ts_pkg;
  localparam int unsigned TS_W_DEF = 5;
  localparam int unsigned NHIT_DEF = 2;

  typedef enum logic {
    PH_DETECT = 1'b0,
    PH_READ   = 1'b1
  } phase_e;
endpackage

// File: rtl/pxl_mask_cell.sv
module pxl_mask_cell (
  input  logic clk,
  input  logic shift_en,
  input  logic ser_in,
  output logic mask_q
);
  // Deliberately not reset: the kill mask survives a master reset.
  always_ff @(posedge clk) begin
    if (shift_en) mask_q <= ser_in;
  end
endmodule

// File: rtl/pxl_hit_store.sv
module pxl_hit_store #(
  parameter int unsigned TS_W = 5,
  parameter int unsigned NHIT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [TS_W-1:0]            ts_bus,
  input  logic                       hit_ok,
  input  logic [NHIT-1:0]            clr_vec,
  output logic [NHIT-1:0]            flags,
  output logic [NHIT-1:0][TS_W-1:0]  stamps
);
  // prior_full[i] is high when every slot below i already holds a hit.
  logic [NHIT:0] prior_full;
  assign prior_full[0] = 1'b1;

  for (genvar i = 0; i < NHIT; i++) begin : g_slot
    logic            flag_q;
    logic [TS_W-1:0] stamp_q;
    logic            take;

    assign prior_full[i+1] = prior_full[i] & flag_q;
    assign take            = hit_ok & prior_full[i] & ~flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (take)       flag_q <= 1'b1;
      else if (clr_vec[i]) flag_q <= 1'b0;
    end

    // Tracks the broadcast bus until the slot is filled, then holds.
    always_ff @(posedge clk) begin
      if (!flag_q) stamp_q <= ts_bus;
    end

    assign flags[i]  = flag_q;
    assign stamps[i] = stamp_q;
  end
endmodule

// File: rtl/pxl_token_ctrl.sv
module pxl_token_ctrl #(
  parameter int unsigned TS_W = 5,
  parameter int unsigned NHIT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_phase,
  input  logic                       tok_in,
  input  logic                       masked,
  input  logic [NHIT-1:0]            flags,
  input  logic [NHIT-1:0][TS_W-1:0]  stamps,
  input  logic                       out_ready,
  output logic                       tok_out,
  output logic                       out_vld,
  output logic [TS_W-1:0]            ts_out,
  output logic [NHIT-1:0]            clr_vec
);
  localparam int unsigned IDX_W = (NHIT > 1) ? $clog2(NHIT) : 1;

  logic             vld_q;
  logic [IDX_W-1:0] cur_q;
  logic [TS_W-1:0]  data_q;
  logic             pending;
  logic             accept;
  logic [NHIT-1:0]  remaining;
  logic [IDX_W-1:0] pick;
  logic             any_rem;
  logic             load;

  assign pending   = (|flags) & ~masked;
  assign tok_out   = tok_in & ~pending;
  assign accept    = vld_q & out_ready;
  assign clr_vec   = accept ? (NHIT'(1) << cur_q) : '0;
  assign remaining = flags & ~clr_vec;

  // Oldest remaining slot is the lowest index still set.
  always_comb begin
    pick    = '0;
    any_rem = 1'b0;
    for (int k = NHIT - 1; k >= 0; k--) begin
      if (remaining[k]) begin
        pick    = IDX_W'(k);
        any_rem = 1'b1;
      end
    end
  end

  assign load = rd_phase & tok_in & any_rem & ~masked & (~vld_q | accept);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      cur_q  <= '0;
      data_q <= '0;
    end else if (load) begin
      vld_q  <= 1'b1;
      cur_q  <= pick;
      data_q <= stamps[pick];
    end else if (accept) begin
      vld_q  <= 1'b0;
    end
  end

  assign out_vld = vld_q;
  assign ts_out  = vld_q ? data_q : '0;
endmodule

// File: rtl/pxl_twohit_cell.sv
module pxl_twohit_cell
  import pxl_ts_pkg::*;
#(
  parameter int unsigned TS_W = TS_W_DEF,
  parameter int unsigned NHIT = NHIT_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] ts_bus,
  input  logic            hit_i,
  input  logic            ro_en,
  input  logic            mask_shift,
  input  logic            mask_si,
  output logic            mask_so,
  input  logic            tok_in,
  output logic            tok_out,
  output logic            get_x,
  output logic            get_y,
  output logic [TS_W-1:0] ts_out,
  input  logic            out_ready
);
  phase_e                     phase;
  logic                       mask_q;
  logic                       hit_ok;
  logic                       out_vld;
  logic [NHIT-1:0]            flags;
  logic [NHIT-1:0]            clr_vec;
  logic [NHIT-1:0][TS_W-1:0]  stamps;

  assign phase  = phase_e'(ro_en);
  assign hit_ok = hit_i & (phase == PH_DETECT) & ~mask_q;

  pxl_mask_cell u_mask (
    .clk      (clk),
    .shift_en (mask_shift),
    .ser_in   (mask_si),
    .mask_q   (mask_q)
  );

  pxl_hit_store #(.TS_W(TS_W), .NHIT(NHIT)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .ts_bus  (ts_bus),
    .hit_ok  (hit_ok),
    .clr_vec (clr_vec),
    .flags   (flags),
    .stamps  (stamps)
  );

  pxl_token_ctrl #(.TS_W(TS_W), .NHIT(NHIT)) u_tok (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_phase  (phase == PH_READ),
    .tok_in    (tok_in),
    .masked    (mask_q),
    .flags     (flags),
    .stamps    (stamps),
    .out_ready (out_ready),
    .tok_out   (tok_out),
    .out_vld   (out_vld),
    .ts_out    (ts_out),
    .clr_vec   (clr_vec)
  );

  assign mask_so = mask_q;
  assign get_x   = out_vld;
  assign get_y   = out_vld;
endmodule

// File: rtl/pxl_twohit_cell_chk.sv
module pxl_twohit_cell_chk #(
  parameter int unsigned TS_W = 5,
  parameter int unsigned NHIT = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ro_en,
  input logic                      tok_in,
  input logic                      tok_out,
  input logic                      get_x,
  input logic                      get_y,
  input logic [TS_W-1:0]           ts_out,
  input logic                      out_ready,
  input logic                      mask_q,
  input logic [NHIT-1:0]           flags,
  input logic [NHIT-1:0][TS_W-1:0] stamps
);
  assert_token_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |-> tok_in);

  assert_hold_token_R8: assert property (@(posedge clk) disable iff (!rst_n)
    get_x |-> !tok_out);

  assert_select_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    get_x == get_y);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (get_x && !out_ready) |=> (get_x && $stable(ts_out)));

  assert_first_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] |=> $stable(stamps[0]));

  if (NHIT > 1) begin : g_second
    assert_second_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flags[1] |=> $stable(stamps[1]));
  end

  assert_third_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((&flags) && !ro_en && !get_x) |=> ((&flags) && $stable(stamps)));

  assert_masked_no_record_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !ro_en && !get_x) |=> $stable(flags));

  assert_readout_no_record_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ro_en |=> ((flags & ~$past(flags)) == '0));
endmodule

bind pxl_twohit_cell pxl_twohit_cell_chk #(.TS_W(TS_W), .NHIT(NHIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ro_en     (ro_en),
  .tok_in    (tok_in),
  .tok_out   (tok_out),
  .get_x     (get_x),
  .get_y     (get_y),
  .ts_out    (ts_out),
  .out_ready (out_ready),
  .mask_q    (mask_q),
  .flags     (flags),
  .stamps    (stamps)
);

// File: tb/pxl_twohit_cell_tb_top.sv
`timescale 1ns/1ps
module pxl_twohit_cell_tb_top;
  localparam int TS_W = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [TS_W-1:0] ts_bus;
  logic            hit_i, ro_en, mask_shift, mask_si, mask_so;
  logic            tok_in, tok_out, get_x, get_y, out_ready;
  logic [TS_W-1:0] ts_out;

  always #2.5 clk = ~clk;

  pxl_twohit_cell dut_i (
    .clk(clk), .rst_n(rst_n), .ts_bus(ts_bus), .hit_i(hit_i), .ro_en(ro_en),
    .mask_shift(mask_shift), .mask_si(mask_si), .mask_so(mask_so),
    .tok_in(tok_in), .tok_out(tok_out), .get_x(get_x), .get_y(get_y),
    .ts_out(ts_out), .out_ready(out_ready)
  );

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R11";

  // Behavioural reference: a queue of stored stamps, oldest first.
  int q[$];
  bit m_mask = 0;
  bit m_mask_known = 0;
  bit m_vld = 0;
  int m_ts = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_vld = 0;
      m_ts  = 0;
    end else begin
      if (m_vld && out_ready) begin
        void'(q.pop_front());
        m_vld = 0;
      end
      if (!ro_en && hit_i && !m_mask && q.size() < 2) q.push_back(int'(ts_bus));
      if (!m_vld && ro_en && tok_in && !m_mask && q.size() > 0) begin
        m_vld = 1;
        m_ts  = q[0];
      end
    end
    if (mask_shift) begin
      m_mask       = mask_si;
      m_mask_known = 1;
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit exp_tok;
    exp_tok = tok_in && !(q.size() > 0 && !m_mask);
    cmp("tok_out", int'(tok_out), int'(exp_tok));
    cmp("get_x", int'(get_x), int'(m_vld));
    cmp("get_y", int'(get_y), int'(m_vld));
    cmp("ts_out", int'(ts_out), m_vld ? m_ts : 0);
    if (m_mask_known) cmp("mask_so", int'(mask_so), int'(m_mask));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
    ts_bus = ts_bus + 1'b1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic hit_pulse();
    hit_i = 1'b1;
    tick();
    hit_i = 1'b0;
  endtask

  task automatic drain();
    ro_en = 1'b1; tok_in = 1'b1; out_ready = 1'b1;
    for (int i = 0; i < 8; i++) tick();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      finish_up();
    end
  end

  initial begin
    bit [15:0] lfsr;
    rst_n = 0; ts_bus = '0; hit_i = 0; ro_en = 0; mask_shift = 1; mask_si = 0;
    tok_in = 0; out_ready = 0;
    // R11 reset state, mask loaded to 0 during reset
    cur_req = "R11"; ticks(3);
    rst_n = 1; mask_shift = 0; tick();

    // R7: empty pixel passes token in the same cycle
    cur_req = "R7"; ro_en = 1;
    for (int i = 0; i < 4; i++) begin tok_in = i[0]; tick(); end
    tok_in = 0;

    // R1/R2/R3: two stored hits, further hits ignored
    cur_req = "R1"; ro_en = 0; ticks(2); hit_pulse(); ticks(3);
    cur_req = "R2"; hit_pulse(); ticks(2);
    cur_req = "R3"; hit_pulse(); hit_pulse(); tick();

    // R8/R9/R10: readout with ready held high
    cur_req = "R8"; ro_en = 1; out_ready = 1; tok_in = 1; ticks(2);
    cur_req = "R9"; tick();
    cur_req = "R10"; ticks(3); tok_in = 0; tick(); tok_in = 1; tick();

    // R9: back-pressure in the middle of a two-word readout
    cur_req = "R9"; ro_en = 0; tok_in = 0; hit_pulse(); tick(); hit_pulse();
    ro_en = 1; tok_in = 1; out_ready = 0; ticks(3);
    out_ready = 1; tick(); out_ready = 0; ticks(2); out_ready = 1; ticks(3);

    // R10: single stored hit
    cur_req = "R10"; ro_en = 0; tok_in = 0; hit_pulse(); ro_en = 1; tok_in = 1; ticks(4);

    // R4: mask chain shifting, output shows stored bit
    cur_req = "R4"; mask_shift = 1; mask_si = 1; tick(); mask_si = 0; tick();
    mask_si = 1; tick(); mask_shift = 0; mask_si = 0; ticks(2);
    // R5: masked pixel records nothing and passes token
    cur_req = "R5"; ro_en = 0; tok_in = 0; hit_pulse(); hit_pulse(); tick();
    ro_en = 1; tok_in = 1; ticks(3);
    // R4: master reset leaves mask set
    cur_req = "R4"; rst_n = 0; ticks(2); rst_n = 1; ticks(2);
    mask_shift = 1; mask_si = 0; tick(); mask_shift = 0; tick();

    // R6: hits during readout ignored
    cur_req = "R6"; ro_en = 1; tok_in = 0; hit_pulse(); hit_pulse(); tick();
    tok_in = 1; ticks(3);

    // R11: reset clears stored hits and a stalled word
    cur_req = "R11"; ro_en = 0; tok_in = 0; hit_pulse(); hit_pulse();
    rst_n = 0; tick(); rst_n = 1; ro_en = 1; tok_in = 1; ticks(3);
    ro_en = 0; tok_in = 0; hit_pulse(); ro_en = 1; tok_in = 1; out_ready = 0; ticks(2);
    rst_n = 0; tick(); rst_n = 1; ticks(2);

    // R9: mixed pattern of hits, tokens and back-pressure
    cur_req = "R9"; lfsr = 16'hACE1;
    for (int t = 0; t < 60; t++) begin
      ro_en = 0; tok_in = 0; out_ready = 0;
      for (int c = 0; c < 20; c++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        hit_i = (lfsr[1:0] == 2'b00);
        tick();
      end
      hit_i = 0; ro_en = 1;
      for (int c = 0; c < 15; c++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tok_in = lfsr[2] | lfsr[5];
        out_ready = lfsr[3];
        tick();
      end
      drain();
    end

    finish_up();
  end
endmodule